// File: doc/BRIEF.md
# ADC Sample and Convert Sequencer

This block paces a successive-approximation converter from the instruction clock. A fractional divider, set by a six-bit field, produces one ADC clock tick (TAD) at a time. A sequencer opens the sample-hold window when software requests it and closes it on the selected trigger. It then runs the conversion for a fixed number of TAD periods, capturing one comparator decision per period, MSB first. When the last period ends it loads the result buffer and raises a done pulse.

The trigger can be a software write, an automatic start after a programmed number of TAD periods, or one of several external pulse inputs. The external inputs are synchronized to the clock and edge-detected. Dropping the module enable aborts an acquisition or conversion in progress. The abort leaves the buffer untouched, outranks a simultaneous auto-start, and blocks new sampling for two TAD periods.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With divisor field D, `tad_tick_o` pulses for one cycle on average every (D+1)/2 clock cycles. For odd D the gap is always (D+1)/2 cycles. For even D≥2 the gaps alternate between D/2 and D/2+1 cycles. D=0 gives a tick every cycle. While `en_i` is low the divider is held at zero and no tick occurs.
- R2: After reset the sample-hold output, done flag and result buffer are zero. A `samp_set_i` pulse while enabled and idle raises `sampling_o`. A `samp_set_i` pulse while disabled has no effect.
- R3: Trigger code 3'b000, and any code not otherwise assigned (3'b100 to 3'b110), is manual mode. A `samp_clr_i` pulse while sampling lowers `sampling_o` and starts a conversion. The conversion gives exactly 12 `bit_strobe_o` ticks before done, and sampling stays low afterwards.
- R4: The first 10 bit strobes of a conversion capture `cmp_bit_i`, MSB first, into `result_o`. The buffer is loaded in the same cycle that `done_o` rises, and `done_o` lasts one cycle.
- R5: Trigger code 3'b111 is auto-start mode. Conversion begins after `samc_i` TAD ticks of sampling, with 0 treated as 1, and sampling restarts by itself after done. Successive done pulses are therefore (samc+12) TAD apart, which is 13 TAD for samc of 1.
- R6: Trigger codes 3'b001, 3'b010 and 3'b011 select `ext_trig_i[0]`, `[1]` and `[2]`. A rising edge on the selected input while sampling starts a conversion after a two-flop synchronizer. Edges on unselected inputs, and a level already high before sampling began, do not start one.
- R7: Lowering `en_i` during sampling or conversion stops the sequence. No done pulse follows, and `result_o` keeps its last completed value.
- R8: If `en_i` falls in the same cycle that an auto-start would begin a conversion, the abort wins: no bit strobe and no done pulse follow.
- R9: After an abort, `samp_set_i` is ignored until two TAD ticks have occurred with `en_i` high again. After that, it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction clock (TCY) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable; falling during activity aborts |
| samp_set_i | input | 1 | Software pulse that opens the sample window |
| samp_clr_i | input | 1 | Software pulse that closes it (manual trigger) |
| trig_sel_i | input | 3 | Trigger source select |
| samc_i | input | 5 | Auto-start sample length in TAD |
| adcs_i | input | 6 | ADC clock divisor field |
| ext_trig_i | input | 3 | External trigger inputs (timer, PWM, pin) |
| cmp_bit_i | input | 1 | Comparator decision from the converter data path |
| tad_tick_o | output | 1 | One-cycle pulse per TAD period |
| sampling_o | output | 1 | Sample-hold control, high while acquiring |
| bit_strobe_o | output | 1 | Per-TAD strobe during conversion |
| done_o | output | 1 | One-cycle pulse when the buffer is loaded |
| result_o | output | 10 | Result buffer |

## Verification
The bench builds the block with its defaults: a 10-bit result, 12 TAD per conversion and three external trigger inputs. With these values every bit position of the buffer can be checked against a known comparator pattern. Divisor values 0, 1, 3 and 4 cover the clamped, integer and half-step divider cases. Most sequencing runs use a divisor of 3, which puts every TAD at two clocks. That makes auto-start spacing, the lockout window and the auto-start/abort collision land on exact, countable cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2,
    ST_LOCK    = 2'd3
  } seq_state_t;

  localparam logic [2:0] TRIG_MANUAL = 3'b000;
  localparam logic [2:0] TRIG_AUTO   = 3'b111;
endpackage

// File: rtl/adc_tad_div.sv
module adc_tad_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int ACC_W = DIV_W + 2;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] limit, sum;
  logic             tick_q, tick_d;

  // half-step accumulator: two half-steps per clock, wrap at div+1 (min 2)
  always_comb begin
    limit = ACC_W'(div_i) + ACC_W'(1);
    if (limit < ACC_W'(2)) limit = ACC_W'(2);
    sum    = acc_q + ACC_W'(2);
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (!en_i) begin
      acc_d = '0;
    end else if (sum >= limit) begin
      acc_d  = sum - limit;
      tick_d = 1'b1;
    end else begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  p_no_tick_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= trig_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int CONV_TAD = 12,
  parameter int SAMC_W   = 5,
  parameter int N_EXT    = 3,
  parameter int LOCK_TAD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              samp_set_i,
  input  logic              samp_clr_i,
  input  logic [2:0]        trig_sel_i,
  input  logic [SAMC_W-1:0] samc_i,
  input  logic              tad_tick_i,
  input  logic [N_EXT-1:0]  ext_rise_i,
  input  logic              cmp_bit_i,
  output logic              sampling_o,
  output logic              bit_strobe_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);
  localparam int CONV_CW = $clog2(CONV_TAD + 1);
  localparam int CNT_W   = (SAMC_W + 1 > CONV_CW) ? SAMC_W + 1 : CONV_CW;

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [RES_W-1:0]  shift_q, shift_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              done_q, done_d;
  logic              auto_mode, ext_mode, ext_hit;
  logic [CNT_W-1:0]  samc_eff;

  // trigger decode: codes 1..N_EXT pick an external lane
  always_comb begin
    auto_mode = (trig_sel_i == TRIG_AUTO);
    ext_mode  = 1'b0;
    ext_hit   = 1'b0;
    for (int i = 0; i < N_EXT; i++) begin
      if (trig_sel_i == 3'(i + 1)) begin
        ext_mode = 1'b1;
        ext_hit  = ext_rise_i[i];
      end
    end
    samc_eff = (samc_i == '0) ? CNT_W'(1) : CNT_W'(samc_i);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    res_d   = res_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (samp_set_i) begin
          state_d = ST_SAMPLE;
          cnt_d   = '0;
        end
      end
      ST_SAMPLE: begin
        if (auto_mode) begin
          if (tad_tick_i) begin
            if (cnt_q + CNT_W'(1) >= samc_eff) begin
              state_d = ST_CONVERT;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end else if (ext_mode) begin
          if (ext_hit) begin
            state_d = ST_CONVERT;
            cnt_d   = '0;
          end
        end else if (samp_clr_i) begin
          state_d = ST_CONVERT;
          cnt_d   = '0;
        end
      end
      ST_CONVERT: begin
        if (tad_tick_i) begin
          if (cnt_q < CNT_W'(RES_W)) begin
            shift_d = {shift_q[RES_W-2:0], cmp_bit_i};
          end
          if (cnt_q == CNT_W'(CONV_TAD - 1)) begin
            res_d   = shift_d;
            done_d  = 1'b1;
            cnt_d   = '0;
            state_d = auto_mode ? ST_SAMPLE : ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_LOCK: begin
        if (tad_tick_i) begin
          if (cnt_q + CNT_W'(1) >= CNT_W'(LOCK_TAD)) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    // enable low outranks every transition above
    if (!en_i) begin
      done_d = 1'b0;
      res_d  = res_q;
      if (state_q == ST_SAMPLE || state_q == ST_CONVERT) begin
        state_d = ST_LOCK;
        cnt_d   = '0;
      end else if (state_q == ST_IDLE) begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      res_q   <= res_d;
      done_q  <= done_d;
    end
  end

  assign sampling_o   = (state_q == ST_SAMPLE);
  assign bit_strobe_o = (state_q == ST_CONVERT) && tad_tick_i;
  assign done_o       = done_q;
  assign result_o     = res_q;

  // R4: done only ends a conversion that saw its last strobe
  p_done_after_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bit_strobe_o));
  // R4: one-cycle done
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7: abort never produces done
  p_abort_no_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !done_o);
  // R7: abort leaves the buffer untouched
  p_abort_keeps_buf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(result_o));
  // R9: lockout never goes straight to sampling
  p_lock_blocks_sample_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK) |=> !sampling_o);
  // R8: enable low with a pending auto-start never enters conversion
  p_abort_beats_auto_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && sampling_o) |=> (state_q != ST_CONVERT));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W    = 10,
  parameter int CONV_TAD = 12,
  parameter int DIV_W    = 6,
  parameter int SAMC_W   = 5,
  parameter int N_EXT    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              samp_set_i,
  input  logic              samp_clr_i,
  input  logic [2:0]        trig_sel_i,
  input  logic [SAMC_W-1:0] samc_i,
  input  logic [DIV_W-1:0]  adcs_i,
  input  logic [N_EXT-1:0]  ext_trig_i,
  input  logic              cmp_bit_i,
  output logic              tad_tick_o,
  output logic              sampling_o,
  output logic              bit_strobe_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             tick;
  logic [N_EXT-1:0] ext_rise;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  adc_tad_div #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .en_i   (en_i),
    .div_i  (adcs_i),
    .tick_o (tick)
  );

  adc_trig_sync #(.N(N_EXT)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .trig_i (ext_trig_i),
    .rise_o (ext_rise)
  );

  adc_seq_core #(
    .RES_W    (RES_W),
    .CONV_TAD (CONV_TAD),
    .SAMC_W   (SAMC_W),
    .N_EXT    (N_EXT)
  ) i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .en_i         (en_i),
    .samp_set_i   (samp_set_i),
    .samp_clr_i   (samp_clr_i),
    .trig_sel_i   (trig_sel_i),
    .samc_i       (samc_i),
    .tad_tick_i   (tick),
    .ext_rise_i   (ext_rise),
    .cmp_bit_i    (cmp_bit_i),
    .sampling_o   (sampling_o),
    .bit_strobe_o (bit_strobe_o),
    .done_o       (done_o),
    .result_o     (result_o)
  );

  assign tad_tick_o = tick;
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en = 1'b0, samp_set = 1'b0, samp_clr = 1'b0;
  logic [2:0]       trig_sel = 3'b000;
  logic [4:0]       samc = 5'd1;
  logic [5:0]       adcs = 6'd3;
  logic [2:0]       ext_trig = 3'b000;
  logic             cmp_bit = 1'b0;
  logic             tad_tick, sampling, bit_strobe, done;
  logic [RES_W-1:0] result;

  logic [RES_W-1:0] pattern = '0;
  int               seen = 0;
  int               last_cnt = 0;
  int               n_checks = 0;
  int               n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .samp_set_i(samp_set),
    .samp_clr_i(samp_clr), .trig_sel_i(trig_sel), .samc_i(samc),
    .adcs_i(adcs), .ext_trig_i(ext_trig), .cmp_bit_i(cmp_bit),
    .tad_tick_o(tad_tick), .sampling_o(sampling), .bit_strobe_o(bit_strobe),
    .done_o(done), .result_o(result)
  );

  // comparator model: present the pattern MSB first, one bit per strobe
  always @(negedge clk) begin
    if (done) last_cnt = seen;
    if (sampling) seen = 0;
    else begin
      cmp_bit = (seen < RES_W) ? pattern[RES_W-1-seen] : 1'b0;
      if (bit_strobe) seen = seen + 1;
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail + 1);
    $finish;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_set();
    samp_set = 1'b1; step(); samp_set = 1'b0;
  endtask

  task automatic pulse_clr();
    samp_clr = 1'b1; step(); samp_clr = 1'b0;
  endtask

  task automatic wait_done(input int max, output int cyc);
    cyc = 0;
    while (!done && cyc < max) begin step(); cyc++; end
  endtask

  // disable, let any lockout expire, leave enabled and idle
  task automatic restart(input logic [2:0] sel, input logic [5:0] div);
    en = 1'b0; step(); step();
    trig_sel = sel; adcs = div; en = 1'b1;
    repeat (8) step();
  endtask

  task automatic t_reset();
    check("R2 reset sampling", int'(sampling), 0);
    check("R2 reset done", int'(done), 0);
    check("R2 reset result", int'(result), 0);
    pulse_set(); step();
    check("R2 set ignored while disabled", int'(sampling), 0);
  endtask

  task automatic gaps(input logic [5:0] div, output int g0, output int g1, output int g2);
    int c;
    int g[3];
    restart(3'b000, div);
    c = 0;
    while (!tad_tick && c < 200) begin step(); c++; end
    for (int k = 0; k < 3; k++) begin
      g[k] = 0;
      do begin step(); g[k]++; end while (!tad_tick && g[k] < 200);
    end
    g0 = g[0]; g1 = g[1]; g2 = g[2];
  endtask

  task automatic t_divider();
    int a, b, c, ticks;
    gaps(6'd1, a, b, c);
    check("R1 D=1 gap", a, 1); check("R1 D=1 gap", c, 1);
    gaps(6'd3, a, b, c);
    check("R1 D=3 gap", a, 2); check("R1 D=3 gap", b, 2);
    gaps(6'd0, a, b, c);
    check("R1 D=0 gap", b, 1);
    gaps(6'd4, a, b, c);
    check("R1 D=4 gap pair", a + b, 5);
    check("R1 D=4 gap pair", b + c, 5);
    check("R1 D=4 gap min", int'(a >= 2 && b >= 2), 1);
    en = 1'b0; step(); ticks = 0;
    repeat (12) begin step(); if (tad_tick) ticks++; end
    check("R1 no tick disabled", ticks, 0);
  endtask

  task automatic t_manual(input logic [2:0] sel, input logic [RES_W-1:0] pat);
    int cyc;
    restart(sel, 6'd3);
    pattern = pat;
    pulse_set(); step();
    check("R2 sampling raised", int'(sampling), 1);
    repeat (5) step();
    pulse_clr();
    check("R3 sampling lowered", int'(sampling), 0);
    wait_done(100, cyc);
    check("R3 strobes per conversion", last_cnt, 12);
    check("R4 result", int'(result), int'(pat));
    step();
    check("R4 done one cycle", int'(done), 0);
    check("R3 no restart in manual", int'(sampling), 0);
  endtask

  task automatic t_auto(input logic [4:0] s, input int tad_n);
    int cyc;
    restart(3'b111, 6'd3);
    samc = s; pattern = 10'h155;
    pulse_set();
    wait_done(200, cyc);
    step();
    check("R5 sampling restarts", int'(sampling), 1);
    wait_done(200, cyc);
    check("R5 done spacing", cyc + 1, tad_n * 2);
    check("R4 result auto", int'(result), 10'h155);
    en = 1'b0; step();
  endtask

  task automatic t_ext();
    int cyc;
    restart(3'b001, 6'd3);
    pattern = 10'h2C3;
    pulse_set();
    ext_trig = 3'b010; repeat (3) step(); ext_trig = 3'b000;
    repeat (8) step();
    check("R6 unselected input ignored", int'(sampling), 1);
    ext_trig = 3'b001; step(); ext_trig = 3'b000;
    cyc = 0;
    while (sampling && cyc < 10) begin step(); cyc++; end
    check("R6 selected edge ends sampling", int'(sampling), 0);
    wait_done(100, cyc);
    check("R6 result ext", int'(result), 10'h2C3);
    ext_trig = 3'b001; repeat (4) step();
    pulse_set();
    repeat (10) step();
    check("R6 stale level ignored", int'(sampling), 1);
    ext_trig = 3'b000;
    en = 1'b0; step();
  endtask

  task automatic t_abort_convert();
    int cyc, dn;
    t_manual(3'b000, 10'h0F1);
    pattern = 10'h3AA;
    pulse_set(); repeat (3) step(); pulse_clr();
    cyc = 0;
    while (seen < 4 && cyc < 50) begin step(); cyc++; end
    en = 1'b0;
    dn = 0;
    repeat (40) begin step(); if (done) dn++; end
    check("R7 no done after abort", dn, 0);
    check("R7 buffer kept", int'(result), 10'h0F1);
    check("R7 sampling stopped", int'(sampling), 0);
  endtask

  task automatic t_abort_priority();
    int cyc, dn, st;
    restart(3'b111, 6'd3);
    samc = 5'd1;
    pulse_set();
    cyc = 0;
    while (!(tad_tick && sampling) && cyc < 20) begin step(); cyc++; end
    en = 1'b0;
    dn = 0; st = 0;
    repeat (30) begin step(); if (done) dn++; if (bit_strobe) st++; end
    check("R8 no strobe after collision", st, 0);
    check("R8 no done after collision", dn, 0);
    check("R8 buffer kept", int'(result), 10'h0F1);
  endtask

  task automatic t_lockout();
    int cnt, cyc;
    trig_sel = 3'b000; adcs = 6'd3;
    en = 1'b1;
    pulse_set(); step();
    check("R9 set ignored in lockout", int'(sampling), 0);
    cnt = 0; cyc = 0;
    while (cnt < 2 && cyc < 30) begin if (tad_tick) cnt++; step(); cyc++; end
    pulse_set();
    check("R9 set accepted after lockout", int'(sampling), 1);
  endtask

  initial begin
    repeat (4) step();
    rst_ni = 1'b1;
    repeat (4) step();
    t_reset();
    t_divider();
    t_manual(3'b000, 10'h2A5);
    t_manual(3'b101, 10'h1C7);
    t_auto(5'd1, 13);
    t_auto(5'd3, 15);
    t_auto(5'd0, 13);
    t_ext();
    t_abort_convert();
    t_abort_priority();
    t_lockout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule